// File: doc/BRIEF.md
# Register Scoreboard Issue Control

This block is the central hazard keeper in front of a set of functional units. It holds one reservation bit per architectural register and a small register file of values. Each decoded instruction names a destination, two sources and a target unit. The block decides in the same cycle whether that instruction may enter. An instruction that gets in is placed in a small in-order window, together with any source values it can already read.

Sources whose producer has not yet written back are recorded by register number. The window watches every writeback and picks up the matching values. Once both operands of an entry are present, the entry is eligible to leave. Each cycle the oldest eligible entry is presented on the dispatch port, with its operand values, its destination and its unit. The surrounding pipeline executes it and later returns the result on the writeback port, which frees the destination register.

Top module: `sb_issue_ctrl`

## Requirements
- R1: After reset no register is reserved, the window is empty (occupancy 0), no dispatch is offered, every register value is 0, and an idle issue port gives no stall.
- R2: An offered instruction whose destination register is reserved, as the bit stands at the start of the cycle, is stalled. The stall output is combinational in that cycle.
- R3: An offered instruction whose target unit has its busy flag high is stalled.
- R4: An offered instruction is stalled when the window holds its full 4 entries at the start of the cycle, even if an entry leaves in that same cycle.
- R5: An accepted instruction reserves its destination from the next cycle on. A writeback clears the reservation of its register from the next cycle on.
- R6: A source that is not reserved is copied into the window entry at acceptance. Later writebacks to that register do not change the value dispatched.
- R7: A reserved source is recorded by register number. The first writeback to that register captures its value. A writeback in the same cycle as acceptance is also captured.
- R8: At most one entry leaves per cycle. It is the oldest entry that holds both operands. The dispatch outputs are combinational from window state, and an entry completed by a capture is offered from the next cycle.
- R9: The occupancy output equals the number of accepted instructions that have not yet been dispatched.
- R10: A writeback stores its value into the register file, so later readers of that register see it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Decoded instruction offered |
| iss_dst | input | RW | Destination register |
| iss_src_a | input | RW | First source register |
| iss_src_b | input | RW | Second source register |
| iss_unit | input | FW | Target functional unit |
| unit_busy | input | NFU | Busy flag per functional unit |
| wb_valid | input | 1 | Writeback this cycle |
| wb_reg | input | RW | Register being written back |
| wb_data | input | DW | Value being written back |
| iss_stall | output | 1 | Offered instruction is not accepted this cycle |
| disp_valid | output | 1 | A window entry leaves this cycle |
| disp_dst | output | RW | Destination of the leaving entry |
| disp_unit | output | FW | Unit of the leaving entry |
| disp_opa | output | DW | First operand value |
| disp_opb | output | DW | Second operand value |
| occupancy | output | CW | Entries held in the window |

## Verification
The stall and all dispatch outputs depend combinationally on the current inputs and window state, so they are due in the cycle of the stimulus. Acceptance, writeback capture, reservation changes and occupancy take effect one edge later. The bench therefore drives inputs at the falling edge and compares the combinational results 1 ns later against its own scoreboard, window queue and program-order register model. It then advances that model as the following rising edge would. Operand values are compared against the values a strictly sequential execution would read, and writebacks return from random latencies so that captures, same-cycle forwards and late overwrites all occur.

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl #(
  parameter int NREG = 16,
  parameter int DW   = 16,
  parameter int WIN  = 4,
  parameter int NFU  = 4,
  localparam int RW  = $clog2(NREG),
  localparam int FW  = $clog2(NFU),
  localparam int CW  = $clog2(WIN + 1),
  localparam int IW  = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [RW-1:0] iss_dst,
  input  logic [RW-1:0] iss_src_a,
  input  logic [RW-1:0] iss_src_b,
  input  logic [FW-1:0] iss_unit,
  input  logic [NFU-1:0] unit_busy,
  input  logic          wb_valid,
  input  logic [RW-1:0] wb_reg,
  input  logic [DW-1:0] wb_data,
  output logic          iss_stall,
  output logic          disp_valid,
  output logic [RW-1:0] disp_dst,
  output logic [FW-1:0] disp_unit,
  output logic [DW-1:0] disp_opa,
  output logic [DW-1:0] disp_opb,
  output logic [CW-1:0] occupancy
);

  logic [NREG-1:0] resv, resv_n;
  logic [DW-1:0]   rf [NREG];

  logic [CW-1:0]   cnt, cnt_n;
  logic [WIN-1:0]  ok_a, ok_b, ok_a_n, ok_b_n;
  logic [RW-1:0]   w_dst [WIN], w_dst_n [WIN];
  logic [FW-1:0]   w_unit [WIN], w_unit_n [WIN];
  logic [RW-1:0]   tag_a [WIN], tag_a_n [WIN];
  logic [RW-1:0]   tag_b [WIN], tag_b_n [WIN];
  logic [DW-1:0]   val_a [WIN], val_a_n [WIN];
  logic [DW-1:0]   val_b [WIN], val_b_n [WIN];

  logic [WIN-1:0]  s_ok_a, s_ok_b;
  logic [DW-1:0]   s_val_a [WIN], s_val_b [WIN];
  logic [WIN-1:0]  rdy;
  logic [IW-1:0]   sel;
  logic            full, iss_fire;
  logic            new_ok_a, new_ok_b;
  logic [DW-1:0]   new_val_a, new_val_b;
  logic [CW-1:0]   ins_pos;

  assign full      = (cnt == CW'(WIN));
  assign iss_stall = iss_valid && (resv[iss_dst] || unit_busy[iss_unit] || full);
  assign iss_fire  = iss_valid && !iss_stall;
  assign occupancy = cnt;

  assign new_ok_a  = !resv[iss_src_a] || (wb_valid && wb_reg == iss_src_a);
  assign new_ok_b  = !resv[iss_src_b] || (wb_valid && wb_reg == iss_src_b);
  assign new_val_a = resv[iss_src_a] ? wb_data : rf[iss_src_a];
  assign new_val_b = resv[iss_src_b] ? wb_data : rf[iss_src_b];

  genvar g;
  generate
    for (g = 0; g < WIN; g++) begin : g_slot
      assign rdy[g] = (CW'(g) < cnt) && ok_a[g] && ok_b[g];
      assign s_ok_a[g]  = ok_a[g] || (wb_valid && tag_a[g] == wb_reg);
      assign s_ok_b[g]  = ok_b[g] || (wb_valid && tag_b[g] == wb_reg);
      assign s_val_a[g] = ok_a[g] ? val_a[g] : wb_data;
      assign s_val_b[g] = ok_b[g] ? val_b[g] : wb_data;
    end
  endgenerate

  always_comb begin
    sel = '0;
    for (int i = WIN - 1; i >= 0; i--)
      if (rdy[i]) sel = IW'(i);
  end

  assign disp_valid = |rdy;
  assign disp_dst   = w_dst[sel];
  assign disp_unit  = w_unit[sel];
  assign disp_opa   = val_a[sel];
  assign disp_opb   = val_b[sel];

  assign ins_pos = cnt - CW'(disp_valid);
  assign cnt_n   = cnt + CW'(iss_fire) - CW'(disp_valid);

  always_comb begin
    for (int j = 0; j < WIN; j++) begin
      int src;
      src = (disp_valid && j >= int'(sel) && j < WIN - 1) ? j + 1 : j;
      ok_a_n[j]   = s_ok_a[src];
      ok_b_n[j]   = s_ok_b[src];
      w_dst_n[j]  = w_dst[src];
      w_unit_n[j] = w_unit[src];
      tag_a_n[j]  = tag_a[src];
      tag_b_n[j]  = tag_b[src];
      val_a_n[j]  = s_val_a[src];
      val_b_n[j]  = s_val_b[src];
      if (iss_fire && CW'(j) == ins_pos) begin
        ok_a_n[j]   = new_ok_a;
        ok_b_n[j]   = new_ok_b;
        w_dst_n[j]  = iss_dst;
        w_unit_n[j] = iss_unit;
        tag_a_n[j]  = iss_src_a;
        tag_b_n[j]  = iss_src_b;
        val_a_n[j]  = new_val_a;
        val_b_n[j]  = new_val_b;
      end
    end
  end

  always_comb begin
    resv_n = resv;
    if (wb_valid) resv_n[wb_reg] = 1'b0;
    if (iss_fire) resv_n[iss_dst] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv <= '0;
      cnt  <= '0;
      ok_a <= '0;
      ok_b <= '0;
      for (int r = 0; r < NREG; r++) rf[r] <= '0;
    end else begin
      resv <= resv_n;
      cnt  <= cnt_n;
      ok_a <= ok_a_n;
      ok_b <= ok_b_n;
      if (wb_valid) rf[wb_reg] <= wb_data;
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < WIN; j++) begin
      w_dst[j]  <= w_dst_n[j];
      w_unit[j] <= w_unit_n[j];
      tag_a[j]  <= tag_a_n[j];
      tag_b[j]  <= tag_b_n[j];
      val_a[j]  <= val_a_n[j];
      val_b[j]  <= val_b_n[j];
    end
  end

  // R9
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(WIN));

  // R5
  resv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire |=> resv[$past(iss_dst)]);

  // R5
  resv_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !(iss_fire && iss_dst == wb_reg)) |=> !resv[$past(wb_reg)]);

  // R8
  disp_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !iss_fire) |=> cnt == $past(cnt) - CW'(1));

  generate
    for (g = 0; g < WIN; g++) begin : g_inv
      // R7
      wait_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (CW'(g) < cnt && !ok_a[g]) |-> resv[tag_a[g]]);
      // R7
      wait_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (CW'(g) < cnt && !ok_b[g]) |-> resv[tag_b[g]]);
    end
  endgenerate

endmodule

// File: tb/sb_issue_ctrl_tb_top.sv
`timescale 1ns/1ps
module sb_issue_ctrl_tb_top;
  localparam int NREG = 16, DW = 16, WIN = 4, NFU = 4;
  localparam int RW = $clog2(NREG), FW = $clog2(NFU), CW = $clog2(WIN + 1);

  logic clk = 0, rst_n = 0;
  logic iss_valid = 0, wb_valid = 0;
  logic [RW-1:0] iss_dst = 0, iss_src_a = 0, iss_src_b = 0, wb_reg = 0;
  logic [FW-1:0] iss_unit = 0;
  logic [NFU-1:0] unit_busy = 0;
  logic [DW-1:0] wb_data = 0;
  logic iss_stall, disp_valid;
  logic [RW-1:0] disp_dst;
  logic [FW-1:0] disp_unit;
  logic [DW-1:0] disp_opa, disp_opb;
  logic [CW-1:0] occupancy;

  always #2.5 clk = ~clk;

  sb_issue_ctrl #(.NREG(NREG), .DW(DW), .WIN(WIN), .NFU(NFU)) dut_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_dst(iss_dst),
    .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_unit(iss_unit),
    .unit_busy(unit_busy), .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data),
    .iss_stall(iss_stall), .disp_valid(disp_valid), .disp_dst(disp_dst),
    .disp_unit(disp_unit), .disp_opa(disp_opa), .disp_opb(disp_opb),
    .occupancy(occupancy));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] calc(input logic [DW-1:0] a, b, input int d, u);
    return DW'(a * 3 + b + d * 17 + u + 1);
  endfunction

  // bench model
  bit   bresv [NREG];
  logic [DW-1:0] mreg [NREG];
  logic [DW-1:0] ea [NREG], eb [NREG], er [NREG];
  int   eu [NREG];
  bit   pend [NREG];
  int   due [NREG];
  int   q_dst [WIN], q_ta [WIN], q_tb [WIN];
  bit   q_oa [WIN], q_ob [WIN];
  int   qn = 0;
  int   cyc = 0;

  task automatic step(input bit v, input int d, sa, sb, u, input logic [NFU-1:0] busy, input string tag);
    bit wv; int wr; bit est, fire; int xi;
    wv = 0; wr = 0;
    @(negedge clk);
    for (int r = 0; r < NREG; r++)
      if (!wv && pend[r] && due[r] <= cyc) begin wv = 1; wr = r; end
    wb_valid = wv; wb_reg = RW'(wr); wb_data = er[wr];
    iss_valid = v; iss_dst = RW'(d); iss_src_a = RW'(sa); iss_src_b = RW'(sb);
    iss_unit = FW'(u); unit_busy = busy;
    #1;
    est = v && (bresv[d] || busy[u] || qn == WIN);
    if (v && bresv[d]) chk(iss_stall == est, {"R2 waw stall ", tag}, iss_stall, est);
    else if (v && busy[u]) chk(iss_stall == est, {"R3 busy stall ", tag}, iss_stall, est);
    else chk(iss_stall == est, {"R4 full/accept ", tag}, iss_stall, est);
    chk(occupancy == CW'(qn), "R9 occupancy", occupancy, qn);
    xi = -1;
    for (int i = WIN - 1; i >= 0; i--) if (i < qn && q_oa[i] && q_ob[i]) xi = i;
    chk(disp_valid == (xi >= 0), "R8 dispatch valid", disp_valid, xi >= 0);
    if (xi >= 0 && disp_valid) begin
      chk(disp_dst == RW'(q_dst[xi]), "R8 oldest ready", disp_dst, q_dst[xi]);
      chk(disp_unit == FW'(eu[q_dst[xi]]), "R8 unit", disp_unit, eu[q_dst[xi]]);
      chk(disp_opa == ea[q_dst[xi]], "R6 R7 operand a", disp_opa, ea[q_dst[xi]]);
      chk(disp_opb == eb[q_dst[xi]], "R6 R7 operand b", disp_opb, eb[q_dst[xi]]);
    end
    fire = v && !est;
    if (xi >= 0) begin
      pend[q_dst[xi]] = 1; due[q_dst[xi]] = cyc + 1 + int'($urandom % 5);
      for (int i = xi; i < WIN - 1; i++) begin
        q_dst[i] = q_dst[i+1]; q_ta[i] = q_ta[i+1]; q_tb[i] = q_tb[i+1];
        q_oa[i] = q_oa[i+1]; q_ob[i] = q_ob[i+1];
      end
      qn--;
    end
    if (wv) for (int i = 0; i < qn; i++) begin
      if (q_ta[i] == wr) q_oa[i] = 1;
      if (q_tb[i] == wr) q_ob[i] = 1;
    end
    if (fire) begin
      q_dst[qn] = d; q_ta[qn] = sa; q_tb[qn] = sb;
      q_oa[qn] = !bresv[sa] || (wv && wr == sa);
      q_ob[qn] = !bresv[sb] || (wv && wr == sb);
      qn++;
      ea[d] = mreg[sa]; eb[d] = mreg[sb]; eu[d] = u;
      er[d] = calc(ea[d], eb[d], d, u);
      mreg[d] = er[d];
    end
    if (wv) begin bresv[wr] = 0; pend[wr] = 0; end
    if (fire) bresv[d] = 1;
    cyc++;
  endtask

  initial begin
    #1000000;
    chk(0, "watchdog", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int r = 0; r < NREG; r++) begin
      bresv[r] = 0; mreg[r] = 0; pend[r] = 0; er[r] = 0; ea[r] = 0; eb[r] = 0; eu[r] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(occupancy == 0, "R1 reset occupancy", occupancy, 0);
    chk(disp_valid == 0, "R1 reset no dispatch", disp_valid, 0);
    chk(iss_stall == 0, "R1 reset no stall", iss_stall, 0);
    rst_n = 1;
    // directed corners
    step(1, 1, 0, 0, 0, 4'b0000, "d0");        // R1 zero operands, R5 reserve r1
    step(1, 1, 2, 3, 1, 4'b0000, "d1");        // R2 second writer of r1
    step(1, 2, 1, 1, 1, 4'b0010, "d2");        // R3 unit 1 busy
    step(1, 2, 1, 0, 2, 4'b0000, "d3");        // R7 waits on r1
    step(1, 3, 0, 0, 3, 4'b0000, "d4");
    step(1, 4, 0, 0, 3, 4'b0000, "d5");
    step(1, 5, 0, 0, 3, 4'b0000, "d6");        // R4 may fill
    step(1, 6, 0, 0, 3, 4'b0000, "d7");
    // random phase
    for (int k = 0; k < 4000; k++) begin
      logic [NFU-1:0] b;
      for (int u = 0; u < NFU; u++) b[u] = ($urandom % 5 == 0);
      step(($urandom % 4) != 0, int'($urandom % 10), int'($urandom % 10),
           int'($urandom % 10), int'($urandom % NFU), b, "rnd");
    end
    // drain: R10 reads after all writebacks
    for (int k = 0; k < 60; k++) step(0, 0, 0, 0, 0, 4'b0000, "drain");
    for (int r = 0; r < 10; r++) step(1, 10 + (r % 6), r, r, 0, 4'b0000, "R10 probe");
    for (int k = 0; k < 40; k++) step(0, 0, 0, 0, 0, 4'b0000, "drain");
    chk(occupancy == 0, "R9 drained", occupancy, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule